// File: doc/BRIEF.md
# Hotplug Slot Status Register File

This block keeps the pending insert and removal state for up to 32 slots on each of several selectable buses, and presents it to host software through a small 32-bit register window. Slot events arrive as per-bus bitmaps. A plug event marks a slot as newly inserted. An unplug request marks a slot as waiting for removal. While any such mark is outstanding, a level interrupt stays raised.

Software first chooses a bus through a select register. It then reads that bus's inserted bitmap, which clears on read in normal mode. It also reads the removal-request bitmap and the removable mask. Writing a slot bitmap to the eject register retires one slot: the block clears that slot's marks and emits a one-cycle eject command carrying the bus and slot numbers. A write-then-read latch returns a platform-supplied index for a chosen slot, fetched through a lookup port.

When reset is released, and again on each sweep request, the block retires every pending removal as an eject, one slot per cycle. It then reloads each bus's removable mask from the non-removable strap inputs. A legacy strap pins the select register to bus 0 and keeps the inserted bitmap from clearing on read.

Top module: `hotplug_regfile`

## Requirements
- R1: While reset is asserted, irq, eject_valid and rsp_valid are low. Once reset is released, the select register reads 0 and every inserted and removal-request bit is 0.
- R2: An access is accepted only when req_be is 4'b1111 and req_addr is one of 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14, and only while no sweep is running. A rejected write changes nothing. A rejected read returns 0.
- R3: A 1 on plug_req[b*32+s] sets inserted bit s of bus b at the next clock edge. Other buses are unaffected.
- R4: A 1 on unplug_req[b*32+s] sets removal-request bit s of bus b at the next clock edge.
- R5: irq is high exactly while at least one inserted or removal-request bit is set on any bus.
- R6: A read of offset 0x00 returns the selected bus's inserted bitmap and clears it, except in legacy mode. A plug event in the same cycle survives the clear.
- R7: Every read request gets rsp_valid one cycle later, with the data in rsp_rdata. Offset 0x04 returns the removal-request bitmap and does not clear it. Offset 0x0C returns the removable mask. Offset 0x08 always reads 0.
- R8: A write to 0x08 takes the lowest set bit of the data as the slot. It clears that slot's inserted and removal-request bits on the selected bus. In the next cycle it drives eject_valid high for exactly one cycle, with eject_bus and eject_slot. Write data of 0 does nothing.
- R9: Offset 0x10 holds the written bus select and reads it back. While the select value is not below the bus count, every read returns 0, and eject and index writes have no effect.
- R10: With legacy_mode high, any write to 0x10 sets the select to 0, and reads of 0x00 leave the inserted bitmap unchanged.
- R11: Every accepted write first clears the index latch. A write to 0x14 then loads lkup_index for the selected bus and the slot given by the lowest set bit of the data; data 0 leaves the latch at 0. A read of 0x14 returns the latch and clears it.
- R12: After reset release, or after a sweep_req pulse, the block ejects each pending removal one per cycle, in ascending bus order and ascending slot order within each bus. It then loads every bus's removable mask with the inverse of fixed_mask for that bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| legacy_mode | input | 1 | Legacy strap: select pinned to 0, no clear on read of inserted bitmap |
| sweep_req | input | 1 | Starts a removal sweep and mask reload |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the register window |
| req_be | input | 4 | Byte enables; must be all ones |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_rdata | output | 32 | Read response data |
| plug_req | input | NUM_BUSES*32 | Per-bus, per-slot insert events |
| unplug_req | input | NUM_BUSES*32 | Per-bus, per-slot removal requests |
| fixed_mask | input | NUM_BUSES*32 | Per-bus, per-slot non-removable flags |
| lkup_bus | output | BUS_W | Bus of the index lookup |
| lkup_slot | output | 5 | Slot of the index lookup |
| lkup_index | input | IDX_W | Index value returned by the lookup |
| irq | output | 1 | Event interrupt level |
| eject_valid | output | 1 | One-cycle eject command |
| eject_bus | output | BUS_W | Bus of the eject command |
| eject_slot | output | 5 | Slot of the eject command |

## Verification
The main function is exercised with single-slot and multi-slot bitmaps. The eject and index writes use data with several bits set, which separates lowest-bit selection from whole-mask action. Events on a bus other than the selected one show that the select isolates buses. Back-to-back reads of the same offset separate the clear-on-read bitmap from the sticky one. The same read pattern run with the legacy strap high and then low shows the strap's effect. A sweep over removals queued on three buses checks the eject order and the mask reload against a changed strap.

// File: rtl/hp_regs_pkg.sv
package hp_regs_pkg;
  localparam int SLOTS  = 32;
  localparam int SLOT_W = 5;

  localparam int OFF_INS = 'h00;
  localparam int OFF_REM = 'h04;
  localparam int OFF_EJ  = 'h08;
  localparam int OFF_RMV = 'h0C;
  localparam int OFF_SEL = 'h10;
  localparam int OFF_IDX = 'h14;

  typedef enum logic [2:0] {
    REG_NONE,
    REG_INS,
    REG_REM,
    REG_EJ,
    REG_RMV,
    REG_SEL,
    REG_IDX
  } reg_id_e;

  // Position of the lowest set bit; MSB of the result set when v is zero.
  function automatic logic [SLOT_W:0] lowest_set(input logic [SLOTS-1:0] v);
    logic [SLOT_W:0] r;
    r = (SLOT_W+1)'(SLOTS);
    for (int i = SLOTS - 1; i >= 0; i--) begin
      if (v[i]) r = (SLOT_W+1)'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/hp_reg_decode.sv
module hp_reg_decode
  import hp_regs_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  output logic              acc_ok,
  output reg_id_e           acc_reg
);
  always_comb begin
    acc_reg = REG_NONE;
    if      (req_addr == ADDR_W'(OFF_INS)) acc_reg = REG_INS;
    else if (req_addr == ADDR_W'(OFF_REM)) acc_reg = REG_REM;
    else if (req_addr == ADDR_W'(OFF_EJ))  acc_reg = REG_EJ;
    else if (req_addr == ADDR_W'(OFF_RMV)) acc_reg = REG_RMV;
    else if (req_addr == ADDR_W'(OFF_SEL)) acc_reg = REG_SEL;
    else if (req_addr == ADDR_W'(OFF_IDX)) acc_reg = REG_IDX;
  end

  assign acc_ok = req_valid && (req_be == 4'hF) && (acc_reg != REG_NONE);
endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
  import hp_regs_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int BUS_W     = 2,
  localparam int TOT      = NUM_BUSES * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TOT-1:0]    plug_req,
  input  logic [TOT-1:0]    unplug_req,
  input  logic [TOT-1:0]    fixed_mask,
  input  logic              clr_en,
  input  logic [BUS_W-1:0]  clr_bus,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic              rdclr_en,
  input  logic [BUS_W-1:0]  rdclr_bus,
  input  logic              rmv_load,
  output logic [TOT-1:0]    ins_flat,
  output logic [TOT-1:0]    rem_flat,
  output logic [TOT-1:0]    rmv_flat
);
  for (genvar b = 0; b < NUM_BUSES; b++) begin : g_bus
    logic [SLOTS-1:0] ins_q, ins_d, rem_q, rem_d, rmv_q, rmv_d;
    logic [SLOTS-1:0] plug_s, unplug_s;
    logic             hit_clr, hit_rd, ins_en, rem_en;

    assign plug_s   = plug_req[b*SLOTS +: SLOTS];
    assign unplug_s = unplug_req[b*SLOTS +: SLOTS];
    assign hit_clr  = clr_en && (clr_bus == BUS_W'(b));
    assign hit_rd   = rdclr_en && (rdclr_bus == BUS_W'(b));
    assign ins_en   = hit_clr || hit_rd || (|plug_s);
    assign rem_en   = hit_clr || (|unplug_s);

    always_comb begin
      ins_d = ins_q;
      rem_d = rem_q;
      if (hit_clr) begin
        ins_d[clr_slot] = 1'b0;
        rem_d[clr_slot] = 1'b0;
      end
      if (hit_rd) ins_d = '0;
      ins_d = ins_d | plug_s;
      rem_d = rem_d | unplug_s;
      rmv_d = ~fixed_mask[b*SLOTS +: SLOTS];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ins_q <= '0;
        rem_q <= '0;
        rmv_q <= '0;
      end else begin
        if (ins_en)   ins_q <= ins_d;
        if (rem_en)   rem_q <= rem_d;
        if (rmv_load) rmv_q <= rmv_d;
      end
    end

    assign ins_flat[b*SLOTS +: SLOTS] = ins_q;
    assign rem_flat[b*SLOTS +: SLOTS] = rem_q;
    assign rmv_flat[b*SLOTS +: SLOTS] = rmv_q;
  end
endmodule

// File: rtl/hp_sweep.sv
module hp_sweep
  import hp_regs_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int BUS_W     = 2,
  localparam int TOT      = NUM_BUSES * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sweep_req,
  input  logic [TOT-1:0]    rem_flat,
  output logic              active,
  output logic              ej_en,
  output logic [BUS_W-1:0]  ej_bus,
  output logic [SLOT_W-1:0] ej_slot,
  output logic              rmv_load
);
  localparam logic [BUS_W-1:0] LAST = BUS_W'(NUM_BUSES - 1);

  logic             active_q, active_d;
  logic [BUS_W-1:0] ptr_q, ptr_d;
  logic [SLOTS-1:0] cur;
  logic [SLOT_W:0]  lb;
  logic             st_en;

  always_comb begin
    cur      = rem_flat[ptr_q*SLOTS +: SLOTS];
    lb       = lowest_set(cur);
    active_d = active_q;
    ptr_d    = ptr_q;
    ej_en    = 1'b0;
    rmv_load = 1'b0;
    if (active_q) begin
      if (!lb[SLOT_W]) begin
        ej_en = 1'b1;
      end else if (ptr_q == LAST) begin
        rmv_load = 1'b1;
        active_d = 1'b0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end else if (sweep_req) begin
      active_d = 1'b1;
      ptr_d    = '0;
    end
  end

  assign st_en = active_q || sweep_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b1;
      ptr_q    <= '0;
    end else if (st_en) begin
      active_q <= active_d;
      ptr_q    <= ptr_d;
    end
  end

  assign active  = active_q;
  assign ej_bus  = ptr_q;
  assign ej_slot = lb[SLOT_W-1:0];
endmodule

// File: rtl/hotplug_regfile.sv
module hotplug_regfile
  import hp_regs_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int IDX_W     = 14,
  localparam int BUS_W    = (NUM_BUSES > 1) ? $clog2(NUM_BUSES) : 1,
  localparam int TOT      = NUM_BUSES * SLOTS,
  localparam int ADDR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              legacy_mode,
  input  logic              sweep_req,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic [TOT-1:0]    plug_req,
  input  logic [TOT-1:0]    unplug_req,
  input  logic [TOT-1:0]    fixed_mask,
  output logic [BUS_W-1:0]  lkup_bus,
  output logic [SLOT_W-1:0] lkup_slot,
  input  logic [IDX_W-1:0]  lkup_index,
  output logic              irq,
  output logic              eject_valid,
  output logic [BUS_W-1:0]  eject_bus,
  output logic [SLOT_W-1:0] eject_slot
);
  logic              dec_ok;
  reg_id_e           acc_reg;
  logic              sweep_active, sw_ej, rmv_load;
  logic [BUS_W-1:0]  sw_bus;
  logic [SLOT_W-1:0] sw_slot;
  logic [TOT-1:0]    ins_flat, rem_flat, rmv_flat;

  logic              rd_acc, wr_acc, in_rng;
  logic [BUS_W-1:0]  cur_bus;
  logic [SLOT_W:0]   wr_bit;
  logic              reg_ej, rdclr_en, clr_en;
  logic [BUS_W-1:0]  clr_bus;
  logic [SLOT_W-1:0] clr_slot;

  logic [31:0]       sel_q, sel_d;
  logic              sel_en;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              idx_en;
  logic              rsp_v_q;
  logic [31:0]       rsp_d_q, rsp_d_d;
  logic              rsp_en;
  logic              ej_v_q;
  logic [BUS_W-1:0]  ej_b_q;
  logic [SLOT_W-1:0] ej_s_q;

  hp_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_be    (req_be),
    .acc_ok    (dec_ok),
    .acc_reg   (acc_reg)
  );

  hp_sweep #(.NUM_BUSES(NUM_BUSES), .BUS_W(BUS_W)) u_sweep (
    .clk       (clk),
    .rst_n     (rst_n),
    .sweep_req (sweep_req),
    .rem_flat  (rem_flat),
    .active    (sweep_active),
    .ej_en     (sw_ej),
    .ej_bus    (sw_bus),
    .ej_slot   (sw_slot),
    .rmv_load  (rmv_load)
  );

  hp_slot_bank #(.NUM_BUSES(NUM_BUSES), .BUS_W(BUS_W)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .plug_req   (plug_req),
    .unplug_req (unplug_req),
    .fixed_mask (fixed_mask),
    .clr_en     (clr_en),
    .clr_bus    (clr_bus),
    .clr_slot   (clr_slot),
    .rdclr_en   (rdclr_en),
    .rdclr_bus  (cur_bus),
    .rmv_load   (rmv_load),
    .ins_flat   (ins_flat),
    .rem_flat   (rem_flat),
    .rmv_flat   (rmv_flat)
  );

  // Access qualification and command decode
  always_comb begin
    rd_acc   = dec_ok && !sweep_active && !req_write;
    wr_acc   = dec_ok && !sweep_active && req_write;
    in_rng   = (sel_q < 32'(NUM_BUSES));
    cur_bus  = sel_q[BUS_W-1:0];
    wr_bit   = lowest_set(req_wdata);
    reg_ej   = wr_acc && (acc_reg == REG_EJ) && in_rng && !wr_bit[SLOT_W];
    rdclr_en = rd_acc && (acc_reg == REG_INS) && in_rng && !legacy_mode;
    clr_en   = reg_ej || sw_ej;
    clr_bus  = sw_ej ? sw_bus : cur_bus;
    clr_slot = sw_ej ? sw_slot : wr_bit[SLOT_W-1:0];
  end

  assign lkup_bus  = cur_bus;
  assign lkup_slot = wr_bit[SLOT_W-1:0];

  // Select and index latch next state
  always_comb begin
    sel_d  = legacy_mode ? '0 : req_wdata;
    sel_en = wr_acc && (acc_reg == REG_SEL);
    idx_d  = '0;
    idx_en = 1'b0;
    if (wr_acc) begin
      idx_en = 1'b1;
      if ((acc_reg == REG_IDX) && in_rng && !wr_bit[SLOT_W]) idx_d = lkup_index;
    end else if (rd_acc && (acc_reg == REG_IDX) && in_rng) begin
      idx_en = 1'b1;
    end
  end

  // Read data mux
  always_comb begin
    rsp_d_d = '0;
    if (rd_acc && in_rng) begin
      case (acc_reg)
        REG_INS: rsp_d_d = ins_flat[cur_bus*SLOTS +: SLOTS];
        REG_REM: rsp_d_d = rem_flat[cur_bus*SLOTS +: SLOTS];
        REG_RMV: rsp_d_d = rmv_flat[cur_bus*SLOTS +: SLOTS];
        REG_SEL: rsp_d_d = sel_q;
        REG_IDX: rsp_d_d = 32'(idx_q);
        default: rsp_d_d = '0;
      endcase
    end
    rsp_en = (req_valid && !req_write) || rsp_v_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      idx_q   <= '0;
      rsp_v_q <= 1'b0;
      rsp_d_q <= '0;
      ej_v_q  <= 1'b0;
      ej_b_q  <= '0;
      ej_s_q  <= '0;
    end else begin
      if (sel_en) sel_q <= sel_d;
      if (idx_en) idx_q <= idx_d;
      if (rsp_en) begin
        rsp_v_q <= req_valid && !req_write;
        rsp_d_q <= rsp_d_d;
      end
      ej_v_q <= clr_en;
      if (clr_en) begin
        ej_b_q <= clr_bus;
        ej_s_q <= clr_slot;
      end
    end
  end

  assign rsp_valid   = rsp_v_q;
  assign rsp_rdata   = rsp_d_q;
  assign irq         = (|ins_flat) || (|rem_flat);
  assign eject_valid = ej_v_q;
  assign eject_bus   = ej_b_q;
  assign eject_slot  = ej_s_q;
endmodule

// File: rtl/hotplug_regfile_chk.sv
module hotplug_regfile_chk
  import hp_regs_pkg::*;
#(
  parameter int NUM_BUSES = 4,
  parameter int BUS_W     = 2,
  localparam int TOT      = NUM_BUSES * SLOTS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              legacy_mode,
  input logic              req_valid,
  input logic              req_write,
  input logic [4:0]        req_addr,
  input logic [TOT-1:0]    plug_req,
  input logic [TOT-1:0]    unplug_req,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              irq,
  input logic              eject_valid,
  input logic [BUS_W-1:0]  eject_bus,
  input logic [SLOT_W-1:0] eject_slot,
  input logic [31:0]       sel_q,
  input logic [TOT-1:0]    ins_flat,
  input logic [TOT-1:0]    rem_flat,
  input logic              wr_acc,
  input reg_id_e           acc_reg
);
  logic [TOT-1:0] unplug_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unplug_prev <= '0;
    else        unplug_prev <= unplug_req;
  end

  AST_PLUG_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|plug_req) |=> ((ins_flat & $past(plug_req)) == $past(plug_req))); // R3

  AST_UNPLUG_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|unplug_req) |=> ((rem_flat & $past(unplug_req)) == $past(unplug_req))); // R4

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|plug_req) || $past(|unplug_req))); // R5

  AST_EJECT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 5'h08) |=> (rsp_valid && rsp_rdata == 32'h0)); // R7

  AST_EJECT_CLEARS_REM: assert property (@(posedge clk) disable iff (!rst_n)
    eject_valid |-> (!rem_flat[{eject_bus, eject_slot}] || unplug_prev[{eject_bus, eject_slot}])); // R8

  AST_OOR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && sel_q >= 32'(NUM_BUSES)) |=> (rsp_rdata == 32'h0)); // R9

  AST_LEGACY_SEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && acc_reg == REG_SEL && legacy_mode) |=> (sel_q == 32'h0)); // R10
endmodule

bind hotplug_regfile hotplug_regfile_chk #(.NUM_BUSES(NUM_BUSES), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .legacy_mode (legacy_mode),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .req_addr    (req_addr),
  .plug_req    (plug_req),
  .unplug_req  (unplug_req),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .irq         (irq),
  .eject_valid (eject_valid),
  .eject_bus   (eject_bus),
  .eject_slot  (eject_slot),
  .sel_q       (sel_q),
  .ins_flat    (ins_flat),
  .rem_flat    (rem_flat),
  .wr_acc      (wr_acc),
  .acc_reg     (acc_reg)
);

// File: tb/test_hotplug_regfile.sv
module test_hotplug_regfile;
  localparam int PERIOD = 10;
  localparam int NB     = 4;
  localparam int BW     = 2;
  localparam int IW     = 14;
  localparam int TOT    = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          legacy_mode, sweep_req;
  logic          req_valid, req_write;
  logic [4:0]    req_addr;
  logic [3:0]    req_be;
  logic [31:0]   req_wdata;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [TOT-1:0] plug_req, unplug_req, fixed_mask;
  logic [BW-1:0] lkup_bus;
  logic [4:0]    lkup_slot;
  logic [IW-1:0] lkup_index;
  logic          irq, eject_valid;
  logic [BW-1:0] eject_bus;
  logic [4:0]    eject_slot;

  int nchk = 0;
  int nbad = 0;
  int ej_cnt = 0;
  logic [6:0] ej_log [32];
  logic [31:0] rd;

  always #(PERIOD/2) clk = ~clk;

  // Platform index: {bus, slot} + 7
  assign lkup_index = IW'({lkup_bus, lkup_slot}) + IW'(7);

  hotplug_regfile #(.NUM_BUSES(NB), .IDX_W(IW)) i_hotplug_regfile (
    .clk(clk), .rst_n(rst_n), .legacy_mode(legacy_mode), .sweep_req(sweep_req),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .plug_req(plug_req), .unplug_req(unplug_req),
    .fixed_mask(fixed_mask), .lkup_bus(lkup_bus), .lkup_slot(lkup_slot),
    .lkup_index(lkup_index), .irq(irq), .eject_valid(eject_valid),
    .eject_bus(eject_bus), .eject_slot(eject_slot)
  );

  always @(posedge clk) begin
    #1;
    if (rst_n && eject_valid && ej_cnt < 32) begin
      ej_log[ej_cnt] = {eject_bus, eject_slot};
      ej_cnt++;
    end
  end

  typedef struct packed {
    logic [1:0]  kind;   // 0 write, 1 read-check, 2 plug, 3 unplug
    logic [4:0]  addr;   // offset, or bus for events
    logic [31:0] data;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 5'h10, 32'h0,   32'h0,        4'd1},   // R1 select resets to 0
    '{2'd1, 5'h0C, 32'h0,   32'hFFFF_FFDD, 4'd12}, // R12 bus0 mask after sweep
    '{2'd1, 5'h00, 32'h0,   32'h0,        4'd1},   // R1 no inserted bits
    '{2'd0, 5'h10, 32'h1,   32'h0,        4'd9},
    '{2'd1, 5'h0C, 32'h0,   32'h7FFF_FFFF, 4'd12}, // R12 bus1 mask
    '{2'd1, 5'h10, 32'h0,   32'h1,        4'd9},   // R9 select readback
    '{2'd2, 5'd1,  32'h11,  32'h0,        4'd3},
    '{2'd1, 5'h00, 32'h0,   32'h11,       4'd3},   // R3 inserted bits
    '{2'd1, 5'h00, 32'h0,   32'h0,        4'd6},   // R6 cleared by read
    '{2'd3, 5'd1,  32'h300, 32'h0,        4'd4},
    '{2'd1, 5'h04, 32'h0,   32'h300,      4'd4},   // R4 removal bits
    '{2'd1, 5'h04, 32'h0,   32'h300,      4'd7},   // R7 not cleared
    '{2'd1, 5'h08, 32'h0,   32'h0,        4'd7},   // R7 eject reads 0
    '{2'd0, 5'h08, 32'h300, 32'h0,        4'd8},
    '{2'd1, 5'h04, 32'h0,   32'h200,      4'd8},   // R8 lowest bit only
    '{2'd0, 5'h10, 32'h0,   32'h0,        4'd9},
    '{2'd2, 5'd1,  32'h4,   32'h0,        4'd3},
    '{2'd1, 5'h00, 32'h0,   32'h0,        4'd3},   // R3 other bus unaffected
    '{2'd0, 5'h10, 32'h1,   32'h0,        4'd9},
    '{2'd1, 5'h00, 32'h0,   32'h4,        4'd3},
    '{2'd0, 5'h14, 32'h50,  32'h0,        4'd11},
    '{2'd1, 5'h14, 32'h0,   32'd43,       4'd11},  // R11 bus1 slot4 -> 43
    '{2'd1, 5'h14, 32'h0,   32'h0,        4'd11},  // R11 cleared by read
    '{2'd0, 5'h14, 32'h50,  32'h0,        4'd11},
    '{2'd0, 5'h10, 32'h1,   32'h0,        4'd11},
    '{2'd1, 5'h14, 32'h0,   32'h0,        4'd11},  // R11 any write clears
    '{2'd0, 5'h14, 32'h0,   32'h0,        4'd11},
    '{2'd1, 5'h14, 32'h0,   32'h0,        4'd11},  // R11 data 0
    '{2'd0, 5'h08, 32'h0,   32'h0,        4'd8},
    '{2'd1, 5'h04, 32'h0,   32'h200,      4'd8},   // R8 data 0 no effect
    '{2'd2, 5'd1,  32'h200, 32'h0,        4'd8},
    '{2'd0, 5'h08, 32'h200, 32'h0,        4'd8},
    '{2'd1, 5'h00, 32'h0,   32'h0,        4'd8},   // R8 inserted cleared
    '{2'd1, 5'h04, 32'h0,   32'h0,        4'd8},   // R8 removal cleared
    '{2'd0, 5'h10, 32'h7,   32'h0,        4'd9},
    '{2'd1, 5'h10, 32'h0,   32'h0,        4'd9},   // R9 out of range
    '{2'd1, 5'h0C, 32'h0,   32'h0,        4'd9},
    '{2'd0, 5'h10, 32'h2,   32'h0,        4'd9},
    '{2'd1, 5'h10, 32'h0,   32'h2,        4'd9},
    '{2'd1, 5'h0C, 32'h0,   32'hFFFF_FFFF, 4'd12},
    '{2'd1, 5'h18, 32'h0,   32'h0,        4'd2}    // R2 offset outside window
  };

  task automatic check(input int r, input logic [31:0] act, input logic [31:0] exp, input string what);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [4:0] a, input logic [31:0] d,
                     input logic [3:0] be, output logic [31:0] q);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    @(negedge clk);
    q = rsp_rdata;
    if (!wr) check(7, {31'h0, rsp_valid}, 32'h1, "read response valid"); // R7
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic ev(input logic rem, input int bus, input logic [31:0] m);
    @(negedge clk);
    if (rem) unplug_req[bus*32 +: 32] = m;
    else     plug_req[bus*32 +: 32] = m;
    @(negedge clk);
    plug_req = '0; unplug_req = '0;
  endtask

  bit done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    int base;
    rst_n = 1'b0; legacy_mode = 1'b0; sweep_req = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = 4'hF; req_wdata = '0;
    plug_req = '0; unplug_req = '0; fixed_mask = '0;
    fixed_mask[0*32 +: 32] = 32'h0000_0022;
    fixed_mask[1*32 +: 32] = 32'h8000_0000;
    repeat (3) @(negedge clk);
    check(1, {29'h0, irq, eject_valid, rsp_valid}, 32'h0, "outputs low in reset"); // R1
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].kind)
        2'd0: acc(1'b1, VEC[i].addr, VEC[i].data, 4'hF, rd);
        2'd1: begin
          acc(1'b0, VEC[i].addr, 32'h0, 4'hF, rd);
          check(int'(VEC[i].req), rd, VEC[i].expv, $sformatf("vector %0d", i));
        end
        2'd2: ev(1'b0, int'(VEC[i].addr), VEC[i].data);
        default: ev(1'b1, int'(VEC[i].addr), VEC[i].data);
      endcase
    end

    // R5 level interrupt
    check(5, {31'h0, irq}, 32'h0, "irq low with nothing pending");
    ev(1'b1, 2, 32'h0001_8000);
    check(5, {31'h0, irq}, 32'h1, "irq high with removal pending");

    // R8 eject pulse contents and width
    base = ej_cnt;
    acc(1'b1, 5'h08, 32'h0001_8000, 4'hF, rd);
    @(negedge clk);
    check(8, ej_cnt - base, 1, "one eject per write");
    check(8, {25'h0, ej_log[base]}, {25'h0, 2'd2, 5'd15}, "eject bus/slot");
    check(8, {31'h0, eject_valid}, 32'h0, "eject pulse one cycle");

    // R2 partial access ignored
    acc(1'b1, 5'h10, 32'h1, 4'h3, rd);
    acc(1'b0, 5'h10, 32'h0, 4'hF, rd);
    check(2, rd, 32'h2, "partial write ignored");
    acc(1'b0, 5'h10, 32'h0, 4'h1, rd);
    check(2, rd, 32'h0, "partial read returns 0");

    // R10 legacy strap
    legacy_mode = 1'b1;
    acc(1'b1, 5'h10, 32'h3, 4'hF, rd);
    acc(1'b0, 5'h10, 32'h0, 4'hF, rd);
    check(10, rd, 32'h0, "legacy select forced to 0");
    ev(1'b0, 0, 32'h1);
    acc(1'b0, 5'h00, 32'h0, 4'hF, rd);
    check(10, rd, 32'h1, "legacy inserted read 1");
    acc(1'b0, 5'h00, 32'h0, 4'hF, rd);
    check(10, rd, 32'h1, "legacy inserted kept");
    legacy_mode = 1'b0;
    acc(1'b0, 5'h00, 32'h0, 4'hF, rd);
    check(6, rd, 32'h1, "normal read returns bit");
    acc(1'b0, 5'h00, 32'h0, 4'hF, rd);
    check(6, rd, 32'h0, "normal read cleared");

    // R12 sweep order and mask reload
    ev(1'b1, 1, 32'h3);
    ev(1'b1, 3, 32'h8000_0000);
    fixed_mask[3*32 +: 32] = 32'h1;
    base = ej_cnt;
    @(negedge clk); sweep_req = 1'b1;
    @(negedge clk); sweep_req = 1'b0;
    repeat (20) @(negedge clk);
    check(12, ej_cnt - base, 4, "sweep eject count");
    check(12, {25'h0, ej_log[base]},   {25'h0, 2'd1, 5'd0},  "sweep eject 1");
    check(12, {25'h0, ej_log[base+1]}, {25'h0, 2'd1, 5'd1},  "sweep eject 2");
    check(12, {25'h0, ej_log[base+2]}, {25'h0, 2'd2, 5'd16}, "sweep eject 3");
    check(12, {25'h0, ej_log[base+3]}, {25'h0, 2'd3, 5'd31}, "sweep eject 4");
    acc(1'b1, 5'h10, 32'h3, 4'hF, rd);
    acc(1'b0, 5'h0C, 32'h0, 4'hF, rd);
    check(12, rd, 32'hFFFF_FFFE, "bus3 mask reloaded");
    acc(1'b0, 5'h04, 32'h0, 4'hF, rd);
    check(12, rd, 32'h0, "bus3 removals retired");
    check(5, {31'h0, irq}, 32'h0, "irq low after sweep");

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule